// File: doc/BRIEF.md
# Scan Test Session Sequencer

This block runs a complete scan test session against a design whose state flip-flops are stitched into one or more serial shift chains. A start pulse in idle launches the session. The block first runs a chain-integrity flush that pushes a fixed period-four bit pattern through every chain. It then steps through a list of stored test vectors. For each vector it shifts the stimulus in, gives one capture clock in normal mode, and unloads the captured response while the next stimulus shifts in. A final shift-only pass unloads the last response.

During the session the block compares every serial output bit and every primary-output bit that matters against stored expected values. It counts the mismatching bits and ends with a one-cycle done pulse and a pass indication. Stimulus words, expected words and don't-care masks sit in three small internal stores that a test environment fills through a write port. All chains shift in parallel for the same number of clocks, which is the `CHAIN_LEN` parameter.

Top module: `scan_test_seq`

## Requirements
- R1: While reset is asserted and after it is released, done, pass, the test-control output, the scan data outputs, the primary-input outputs and the mismatch count are all zero.
- R2: A start pulse in idle begins a flush of CHAIN_LEN+4 cycles with test control low. In flush cycle k (counted from 0), every chain's scan input is bit 1 of k, which gives the repeating sequence 0,0,1,1.
- R3: In flush cycle k with k >= CHAIN_LEN, each chain's serial output is compared with bit 1 of (k - CHAIN_LEN). Flush cycles with k < CHAIN_LEN are not compared.
- R4: Each vector takes CHAIN_LEN shift cycles with test control low, then exactly one capture cycle with test control high. In shift slot j, chain c receives stimulus-word bit j*NUM_CHAINS+c. In the capture cycle, the primary-input outputs carry stimulus-word bits [CH_BITS+PI_W-1:CH_BITS], where CH_BITS = NUM_CHAINS*CHAIN_LEN.
- R5: In shift slot j of vector v (v >= 1), chain c's serial output is compared with bit j*NUM_CHAINS+c of expected word v-1. The shifts of vector 0 are never compared. After the last capture, CHAIN_LEN further shift cycles compare the last vector's expected word in the same way.
- R6: In the capture cycle of vector v, the primary inputs from the tested design are compared with bits [CH_BITS+PO_W-1:CH_BITS] of expected word v.
- R7: A mask bit of 1 at the same position as an expected bit removes that bit from comparison. A mask bit of 0 keeps it.
- R8: The mismatch count rises by the number of mismatching compared bits in each cycle, counting each chain separately, and saturates at 2^CNT_W-1.
- R9: Done is high for exactly one cycle, after exactly (NUM_VEC+2)*CHAIN_LEN+NUM_VEC+4 session cycles. From that cycle until the next accepted start, pass is high exactly when the held count is zero.
- R10: A start pulse while a session is running has no effect on timing or on the count.
- R11: A write with ld_we high stores ld_data at vector ld_addr. ld_sel 0 selects the stimulus store, 1 the expected store and 2 the mask store. ld_sel 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Session launch pulse, honoured only in idle |
| ld_we | input | 1 | Store write strobe |
| ld_sel | input | 2 | Store select: 0 stimulus, 1 expected, 2 mask |
| ld_addr | input | VEC_AW | Vector index for the write |
| ld_data | input | LD_W | Word written |
| scan_si | output | NUM_CHAINS | Serial data into each chain |
| test_ctl | output | 1 | High on capture cycles only |
| dut_pi | output | PI_W | Primary inputs of the tested design |
| scan_so | input | NUM_CHAINS | Serial data out of each chain |
| dut_po | input | PO_W | Primary outputs of the tested design |
| mism_cnt | output | CNT_W | Saturating mismatch count |
| pass | output | 1 | Last session ended with zero mismatches |
| done | output | 1 | One-cycle end-of-session pulse |

## Verification
A behavioural scan-wrapped design in the bench runs six sessions, each with a different fault pattern. A clean run checks that the timing and the drive pattern produce zero mismatches. Inverting the serial outputs only during the flush shows that exactly four bits per chain are compared there and that both chains count in the same cycle. Inverting them only during the first load shows that this window is never compared. Corrupting chosen expected and mask words separates the serial compare, the primary-output compare and the masking. Inverting everything drives the count into saturation, and a start pulse in the middle of a clean session must leave its end time and its count unchanged.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_FLUSH,
    SQ_LOAD,
    SQ_CAPT,
    SQ_DRAIN,
    SQ_END
  } sq_state_e;

  localparam logic [1:0] SEL_STIM = 2'd0;
  localparam logic [1:0] SEL_EXP  = 2'd1;
  localparam logic [1:0] SEL_MASK = 2'd2;

endpackage

// File: rtl/scan_seq_rom.sv
module scan_seq_rom #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 3,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 4,
  parameter int NUM_VEC   = 3,
  localparam int SLOT_W = $clog2(CHAIN_LEN + 4),
  localparam int VEC_AW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output sq_state_e         state_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [VEC_AW-1:0] vec_o,
  output logic              launch_o,
  output logic              done_o,
  output logic              tc_o,
  output logic              fin_o
);

  localparam logic [SLOT_W-1:0] FLUSH_LAST = SLOT_W'(CHAIN_LEN + 3);
  localparam logic [SLOT_W-1:0] SHIFT_LAST = SLOT_W'(CHAIN_LEN - 1);
  localparam logic [VEC_AW-1:0] VEC_LAST   = VEC_AW'(NUM_VEC - 1);

  sq_state_e         st_q, st_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [VEC_AW-1:0] vec_q, vec_d;
  logic              fin_q, fin_d;
  logic              launch;

  always_comb begin
    st_d   = st_q;
    slot_d = slot_q;
    vec_d  = vec_q;
    fin_d  = fin_q;
    launch = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (start) begin
          st_d   = SQ_FLUSH;
          slot_d = '0;
          vec_d  = '0;
          fin_d  = 1'b0;
          launch = 1'b1;
        end
      end
      SQ_FLUSH: begin
        if (slot_q == FLUSH_LAST) begin
          st_d   = SQ_LOAD;
          slot_d = '0;
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end
      SQ_LOAD: begin
        if (slot_q == SHIFT_LAST) begin
          st_d   = SQ_CAPT;
          slot_d = '0;
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end
      SQ_CAPT: begin
        if (vec_q == VEC_LAST) begin
          st_d = SQ_DRAIN;
        end else begin
          st_d  = SQ_LOAD;
          vec_d = vec_q + 1'b1;
        end
      end
      SQ_DRAIN: begin
        if (slot_q == SHIFT_LAST) begin
          st_d   = SQ_END;
          slot_d = '0;
          fin_d  = 1'b1;
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end
      SQ_END: begin
        st_d = SQ_IDLE;
      end
      default: begin
        st_d = SQ_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      slot_q <= '0;
      vec_q  <= '0;
      fin_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      slot_q <= slot_d;
      vec_q  <= vec_d;
      fin_q  <= fin_d;
    end
  end

  assign state_o  = st_q;
  assign slot_o   = slot_q;
  assign vec_o    = vec_q;
  assign launch_o = launch;
  assign done_o   = (st_q == SQ_END);
  assign tc_o     = (st_q == SQ_CAPT);
  assign fin_o    = fin_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(st_q) == SQ_DRAIN);

  // R4
  single_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |=> !tc_o);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SQ_IDLE && start) |=> (st_q != SQ_FLUSH || $past(st_q) == SQ_FLUSH));

  // R2
  flush_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_FLUSH) |-> slot_q <= FLUSH_LAST);

endmodule

// File: rtl/scan_seq_cmp.sv
module scan_seq_cmp #(
  parameter int NUM_CHAINS = 2,
  parameter int PO_W       = 2,
  parameter int CNT_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  chain_en,
  input  logic                  po_en,
  input  logic [NUM_CHAINS-1:0] so,
  input  logic [NUM_CHAINS-1:0] so_exp,
  input  logic [NUM_CHAINS-1:0] so_mask,
  input  logic [PO_W-1:0]       po,
  input  logic [PO_W-1:0]       po_exp,
  input  logic [PO_W-1:0]       po_mask,
  output logic [CNT_W-1:0]      cnt_o
);

  localparam int NB = NUM_CHAINS + PO_W;
  localparam int PW = $clog2(NB + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] STEP_MAX = CNT_W'(NB);

  logic [NB-1:0]     miss;
  logic [PW-1:0]     pop;
  logic [CNT_W:0]    sum_w;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    miss = '0;
    if (chain_en) begin
      miss[NUM_CHAINS-1:0] = (so ^ so_exp) & ~so_mask;
    end
    if (po_en) begin
      miss[NB-1:NUM_CHAINS] = (po ^ po_exp) & ~po_mask;
    end
  end

  always_comb begin
    pop = '0;
    for (int i = 0; i < NB; i++) begin
      pop = pop + PW'(miss[i]);
    end
  end

  always_comb begin
    sum_w  = {1'b0, cnt_q} + (CNT_W + 1)'(pop);
    cnt_en = clr || (pop != '0);
    if (clr) begin
      cnt_d = '0;
    end else if (sum_w[CNT_W]) begin
      cnt_d = CNT_MAX;
    end else begin
      cnt_d = sum_w[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R8
  no_decrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cnt_q >= $past(cnt_q));

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr) |=> cnt_q == CNT_MAX);

  // R8
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q - $past(cnt_q)) <= STEP_MAX);

endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq
  import scan_seq_pkg::*;
#(
  parameter int NUM_CHAINS = 2,
  parameter int CHAIN_LEN  = 4,
  parameter int NUM_VEC    = 3,
  parameter int PI_W       = 2,
  parameter int PO_W       = 2,
  parameter int CNT_W      = 16,
  localparam int VEC_AW  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int CH_BITS = NUM_CHAINS * CHAIN_LEN,
  localparam int SW      = CH_BITS + PI_W,
  localparam int RW      = CH_BITS + PO_W,
  localparam int LD_W    = (SW > RW) ? SW : RW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  ld_we,
  input  logic [1:0]            ld_sel,
  input  logic [VEC_AW-1:0]     ld_addr,
  input  logic [LD_W-1:0]       ld_data,
  output logic [NUM_CHAINS-1:0] scan_si,
  output logic                  test_ctl,
  output logic [PI_W-1:0]       dut_pi,
  input  logic [NUM_CHAINS-1:0] scan_so,
  input  logic [PO_W-1:0]       dut_po,
  output logic [CNT_W-1:0]      mism_cnt,
  output logic                  pass,
  output logic                  done
);

  localparam int SLOT_W = $clog2(CHAIN_LEN + 4);
  localparam logic [SLOT_W-1:0] LEN_S = SLOT_W'(CHAIN_LEN);

  sq_state_e         st;
  logic [SLOT_W-1:0] slot;
  logic [VEC_AW-1:0] vec;
  logic              launch, fin, tc;

  logic [VEC_AW-1:0] exp_addr;
  logic [SW-1:0]     stim_word;
  logic [RW-1:0]     exp_word, msk_word;

  logic [NUM_CHAINS-1:0] stim_bits, exp_bits, msk_bits;
  logic [NUM_CHAINS-1:0] so_exp, so_mask;
  logic                  chain_en, flush_exp;

  scan_seq_fsm #(
    .CHAIN_LEN (CHAIN_LEN),
    .NUM_VEC   (NUM_VEC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .state_o  (st),
    .slot_o   (slot),
    .vec_o    (vec),
    .launch_o (launch),
    .done_o   (done),
    .tc_o     (tc),
    .fin_o    (fin)
  );

  // Shift compares of vector v look at the response of v-1.
  assign exp_addr = (st == SQ_LOAD) ? (vec - VEC_AW'(1)) : vec;

  scan_seq_rom #(.WIDTH(SW), .DEPTH(NUM_VEC)) u_stim_rom (
    .clk   (clk),
    .we    (ld_we && (ld_sel == SEL_STIM)),
    .waddr (ld_addr),
    .wdata (ld_data[SW-1:0]),
    .raddr (vec),
    .rdata (stim_word)
  );

  scan_seq_rom #(.WIDTH(RW), .DEPTH(NUM_VEC)) u_exp_rom (
    .clk   (clk),
    .we    (ld_we && (ld_sel == SEL_EXP)),
    .waddr (ld_addr),
    .wdata (ld_data[RW-1:0]),
    .raddr (exp_addr),
    .rdata (exp_word)
  );

  scan_seq_rom #(.WIDTH(RW), .DEPTH(NUM_VEC)) u_mask_rom (
    .clk   (clk),
    .we    (ld_we && (ld_sel == SEL_MASK)),
    .waddr (ld_addr),
    .wdata (ld_data[RW-1:0]),
    .raddr (exp_addr),
    .rdata (msk_word)
  );

  // Pick the per-chain bits of the current shift slot.
  always_comb begin
    stim_bits = '0;
    exp_bits  = '0;
    msk_bits  = '0;
    for (int j = 0; j < CHAIN_LEN; j++) begin
      if (slot == SLOT_W'(j)) begin
        stim_bits = stim_word[j*NUM_CHAINS +: NUM_CHAINS];
        exp_bits  = exp_word[j*NUM_CHAINS +: NUM_CHAINS];
        msk_bits  = msk_word[j*NUM_CHAINS +: NUM_CHAINS];
      end
    end
  end

  // Flush pattern bit seen at the chain end CHAIN_LEN cycles later.
  assign flush_exp = |((slot - LEN_S) & SLOT_W'(2));

  always_comb begin
    scan_si  = '0;
    dut_pi   = '0;
    chain_en = 1'b0;
    so_exp   = exp_bits;
    so_mask  = msk_bits;
    unique case (st)
      SQ_FLUSH: begin
        scan_si  = {NUM_CHAINS{slot[1]}};
        chain_en = (slot >= LEN_S);
        so_exp   = {NUM_CHAINS{flush_exp}};
        so_mask  = '0;
      end
      SQ_LOAD: begin
        scan_si  = stim_bits;
        chain_en = (vec != '0);
      end
      SQ_CAPT: begin
        dut_pi = stim_word[CH_BITS +: PI_W];
      end
      SQ_DRAIN: begin
        chain_en = 1'b1;
      end
      default: begin
        scan_si = '0;
      end
    endcase
  end

  scan_seq_cmp #(
    .NUM_CHAINS (NUM_CHAINS),
    .PO_W       (PO_W),
    .CNT_W      (CNT_W)
  ) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (launch),
    .chain_en (chain_en),
    .po_en    (tc),
    .so       (scan_so),
    .so_exp   (so_exp),
    .so_mask  (so_mask),
    .po       (dut_po),
    .po_exp   (exp_word[CH_BITS +: PO_W]),
    .po_mask  (msk_word[CH_BITS +: PO_W]),
    .cnt_o    (mism_cnt)
  );

  assign test_ctl = tc;
  assign pass     = fin && (mism_cnt == '0);

  // R4
  pi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_ctl |-> dut_pi == '0);

  // R9
  pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass && !start) |=> pass);

endmodule

// File: tb/scan_test_seq_bench.sv
module scan_test_seq_bench;

  localparam int NCH = 2;
  localparam int L   = 4;
  localparam int NV  = 3;
  localparam int PIW = 2;
  localparam int POW = 2;
  localparam int CW  = 4;
  localparam int CHB = NCH * L;
  localparam int LDW = CHB + PIW;
  localparam int F   = L + 4;
  localparam int S   = (NV + 2) * L + NV + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ld_we = 1'b0;
  logic [1:0] ld_sel = '0;
  logic [1:0] ld_addr = '0;
  logic [LDW-1:0] ld_data = '0;
  logic [NCH-1:0] scan_si, scan_so;
  logic test_ctl, pass, done;
  logic [PIW-1:0] dut_pi;
  logic [POW-1:0] dut_po;
  logic [CW-1:0] mism_cnt;

  logic inv_so = 1'b0;
  logic inv_po = 1'b0;
  logic [7:0] core;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  scan_test_seq #(
    .NUM_CHAINS (NCH), .CHAIN_LEN (L), .NUM_VEC (NV),
    .PI_W (PIW), .PO_W (POW), .CNT_W (CW)
  ) u_scan_test_seq (
    .clk (clk), .rst_n (rst_n), .start (start),
    .ld_we (ld_we), .ld_sel (ld_sel), .ld_addr (ld_addr), .ld_data (ld_data),
    .scan_si (scan_si), .test_ctl (test_ctl), .dut_pi (dut_pi),
    .scan_so (scan_so), .dut_po (dut_po),
    .mism_cnt (mism_cnt), .pass (pass), .done (done)
  );

  function automatic logic [7:0] nxt_f(input logic [7:0] s, input logic [1:0] p);
    logic [7:0] n;
    for (int i = 0; i < 8; i++) begin
      n[i] = s[i] ^ s[(i + 1) % 8] ^ p[i % 2] ^ (s[(i + 3) % 8] & s[(i + 5) % 8]);
    end
    return n;
  endfunction

  function automatic logic [1:0] po_f(input logic [7:0] s, input logic [1:0] p);
    return {(s[0] & s[5]) ^ p[1], (s[3] | s[6]) ^ p[0]};
  endfunction

  // Toy scan-wrapped design: chain c holds core[c*4 +: 4], output cell 3.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core <= '0;
    end else if (test_ctl) begin
      core <= nxt_f(core, dut_pi);
    end else begin
      core[3:0] <= {core[2:0], scan_si[0]};
      core[7:4] <= {core[6:4], scan_si[1]};
    end
  end

  assign scan_so = {core[7], core[3]} ^ {NCH{inv_so}};
  assign dut_po  = po_f(core, dut_pi) ^ {POW{inv_po}};

  function automatic logic [7:0] sv_f(input int v);
    return 8'(v * 77 + 19);
  endfunction

  function automatic logic [1:0] pv_f(input int v);
    return 2'(v + 1);
  endfunction

  function automatic logic [LDW-1:0] stim_w(input int v);
    logic [LDW-1:0] w;
    logic [7:0] s;
    s = sv_f(v);
    for (int j = 0; j < L; j++)
      for (int c = 0; c < NCH; c++)
        w[j*NCH + c] = s[c*4 + 3 - j];
    w[CHB +: PIW] = pv_f(v);
    return w;
  endfunction

  function automatic logic [LDW-1:0] exp_w(input int v);
    logic [LDW-1:0] w;
    logic [7:0] n;
    n = nxt_f(sv_f(v), pv_f(v));
    for (int j = 0; j < L; j++)
      for (int c = 0; c < NCH; c++)
        w[j*NCH + c] = n[c*4 + 3 - j];
    w[CHB +: POW] = po_f(sv_f(v), pv_f(v));
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exv);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int a, input logic [LDW-1:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_sel = sel; ld_addr = 2'(a); ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  // mode: 0 clean, 1 invert chains in flush, 2 invert chains in first load, 3 invert all
  task automatic run_session(input int mode, input int exp_cnt, input bit mid_start, input string tag);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    for (int k = 0; k <= S; k++) begin
      @(negedge clk);
      start  = (mid_start && k == 10);
      inv_so = (mode == 1 && k < F) || (mode == 2 && k >= F && k < F + L) || (mode == 3);
      inv_po = (mode == 3);
      if (k == S) begin
        chk(done == 1'b1, {"R9 done at end ", tag}, done, 1);
        chk(mism_cnt == CW'(exp_cnt), {"R8 count ", tag}, mism_cnt, exp_cnt);
        chk(pass == (exp_cnt == 0), {"R9 pass ", tag}, pass, exp_cnt == 0);
      end else begin
        logic exp_tc;
        logic [NCH-1:0] exp_si;
        logic [PIW-1:0] exp_pi;
        exp_tc = 1'b0; exp_si = '0; exp_pi = '0;
        if (k < F) begin
          exp_si = {NCH{k[1]}};
        end else if (k < F + NV * (L + 1)) begin
          int r, v, j;
          logic [LDW-1:0] w;
          r = k - F; v = r / (L + 1); j = r % (L + 1);
          w = stim_w(v);
          if (j < L) exp_si = w[j*NCH +: NCH];
          else begin
            exp_tc = 1'b1;
            exp_pi = w[CHB +: PIW];
          end
        end
        chk(done == 1'b0, {"R9 early done ", tag}, done, 0);
        chk(test_ctl == exp_tc, {"R4 test control ", tag}, test_ctl, exp_tc);
        chk(scan_si == exp_si, (k < F) ? {"R2 flush drive ", tag} : {"R4 shift drive ", tag}, scan_si, exp_si);
        chk(dut_pi == exp_pi, {"R4 capture inputs ", tag}, dut_pi, exp_pi);
      end
    end
    @(negedge clk);
    inv_so = 1'b0; inv_po = 1'b0;
    chk(done == 1'b0, {"R9 done one cycle ", tag}, done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done == 1'b0 && pass == 1'b0, "R1 reset done/pass", {done, pass}, 0);
    chk(test_ctl == 1'b0 && scan_si == '0 && dut_pi == '0, "R1 reset drive", {test_ctl, scan_si, dut_pi}, 0);
    chk(mism_cnt == '0, "R1 reset count", mism_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && pass == 1'b0 && mism_cnt == '0, "R1 after release", {done, pass, mism_cnt}, 0);

    for (int v = 0; v < NV; v++) begin
      wr(2'd0, v, stim_w(v));
      wr(2'd1, v, exp_w(v));
      wr(2'd2, v, '0);
    end
    // R11: select 3 stores nothing
    wr(2'd3, 0, '1);
    wr(2'd3, 1, '1);

    run_session(0, 0, 1'b0, "clean R11");
    repeat (5) @(negedge clk);
    chk(pass == 1'b1 && mism_cnt == '0, "R9 result held", {pass, mism_cnt}, 2'b10);

    run_session(1, 2 * L, 1'b0, "flush inverted R3");
    run_session(2, 0, 1'b0, "first load inverted R5");

    // R6 R7: flip chain0 slot0 of vec1, PO bit0 of vec0, masked chain1 slot3 of vec2
    wr(2'd1, 1, exp_w(1) ^ LDW'(1));
    wr(2'd1, 0, exp_w(0) ^ (LDW'(1) << CHB));
    wr(2'd1, 2, exp_w(2) ^ (LDW'(1) << 7));
    wr(2'd2, 2, LDW'(1) << 7);
    run_session(0, 2, 1'b0, "corrupted expected R6 R7");
    wr(2'd1, 0, exp_w(0));
    wr(2'd1, 1, exp_w(1));
    wr(2'd1, 2, exp_w(2));
    wr(2'd2, 2, '0);

    run_session(3, (1 << CW) - 1, 1'b0, "all inverted saturate R8");
    run_session(0, 0, 1'b1, "busy start R10");

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule